// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Controller

This block sequences the commands for one DRAM bank. A request carries a row, a column and an identifier; the controller accepts one request at a time and works out what the row buffer holds. If no row is latched, it activates the row and then reads. If the requested row is already latched, it reads at once. If a different row is latched, it precharges, activates and reads. Each command occupies one time step of `STEP_CYC` clock cycles. One step stands for 20 ns; the default of 5 cycles matches a 250 MHz clock. When the column step ends, the block raises a one-cycle completion strobe that returns the request's identifier.

A page-policy input picks between two behaviours. With the open-row policy the row stays latched after the read, so a later request to the same row costs one step. With the closed-row policy the controller issues a precharge right after the read, so the next request finds the bank empty. The policy is sampled when a request is accepted. Bus transfer, queuing, refresh and data movement are outside the block; only bank timing sets the finish time.

States: `ST_IDLE` (bank free, ready to accept), `ST_PRE` (conflict precharge), `ST_ACT` (activate), `ST_COL` (column read), `ST_CLOSE` (closed-policy precharge). Transitions:
- `ST_IDLE` to `ST_ACT` on accept with no row latched.
- `ST_IDLE` to `ST_COL` on accept with the requested row latched.
- `ST_IDLE` to `ST_PRE` on accept with another row latched.
- `ST_PRE` to `ST_ACT` at the end of the step.
- `ST_ACT` to `ST_COL` at the end of the step.
- `ST_COL` to `ST_IDLE` at the end of the step under the open policy.
- `ST_COL` to `ST_CLOSE` at the end of the step under the closed policy.
- `ST_CLOSE` to `ST_IDLE` at the end of the step.

Top module: `bank_rowbuf_ctrl`

## Requirements
- R1: After reset the bank has no row latched. `bank_open` is 0, `req_ready` is 1, `busy` is 0, and there is no command and no completion.
- R2: A request to a bank with no row latched issues ACT and then RD. Command codes on `cmd_kind` are 1=PRE, 2=ACT, 3=RD. `done_valid` is high in cycle 2*STEP_CYC counted from the accepting edge, where the cycle right after that edge is cycle 1. Under the open policy the row stays latched afterwards, and `bank_row` shows it.
- R3: A request to the latched row issues only RD and completes in cycle STEP_CYC.
- R4: A request to a row other than the latched one issues PRE, ACT and RD, in that order, and completes in cycle 3*STEP_CYC. The new row is then latched.
- R5: With the closed policy (`policy_closed`=1), a PRE is issued in the cycle after `done_valid`. The bank stays busy for one more step and is then left with no row latched, so the next request costs 2*STEP_CYC cycles. The row-buffer state alone decides the commands before the read, so a row still latched from the open policy is hit or replaced as under R3 or R4.
- R6: Only one request is in service at a time. `req_ready` is 0 while `busy` is 1. A request held valid during service is accepted at the edge that ends the cycle following the completion strobe.
- R7: `policy_closed` is sampled only at the accepting edge. Changing it during service has no effect on that request.
- R8: `done_valid` is high for exactly one cycle per request. `done_id` carries the request's ID, and requests complete in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_closed | input | 1 | Page policy: 0 open-row, 1 closed-row |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bank idle, request taken on this edge |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| req_id | input | ID_W | Request identifier |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_kind | output | 2 | 1=PRE, 2=ACT, 3=RD |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| done_valid | output | 1 | Completion strobe |
| done_id | output | ID_W | ID of the completed request |
| busy | output | 1 | Bank in service |
| bank_open | output | 1 | A row is latched in the row buffer |
| bank_row | output | ROW_W | Latched row |

## Verification
Directed requests are run against an empty bank, against the same row, and against a different row. The latency and the count of each command kind separate the three row-buffer cases. A request held while the bank is busy shows that service is serialised and that completion identifiers come back in order. Flipping the policy mid-service and then running closed-policy requests separates policy sampling at acceptance from the trailing precharge. It also covers the hit on a row left latched from the open policy.

// File: rtl/bank_rowbuf_pkg.sv
package bank_rowbuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_CLOSE
    } bank_st_t;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_RD  = 2'd3
    } bank_cmd_t;
endpackage

// File: rtl/bank_step_timer.sv
module bank_step_timer #(
    parameter int STEP_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_first,
    output logic step_last
);
    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (!run)      cnt <= '0;
        else if (step_last) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign step_first = (cnt == '0);
    assign step_last  = (cnt == LAST_V);

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_V);
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
    import bank_rowbuf_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic [ROW_W-1:0] cmd_row,
    output logic             open_q,
    output logic [ROW_W-1:0] row_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (cmd_valid) begin
            if (cmd_kind == CMD_ACT) begin
                open_q <= 1'b1;
                row_q  <= cmd_row;
            end else if (cmd_kind == CMD_PRE) begin
                open_q <= 1'b0;
            end
        end
    end

    a_r2_act_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_ACT) |-> !open_q);
    a_r4_pre_on_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_PRE) |-> open_q);
    a_r3_read_matches_row: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_RD) |-> (open_q && row_q == cmd_row));
endmodule

// File: rtl/bank_rowbuf_ctrl.sv
module bank_rowbuf_ctrl
    import bank_rowbuf_pkg::*;
#(
    parameter int ROW_W    = 8,
    parameter int COL_W    = 6,
    parameter int ID_W     = 4,
    parameter int STEP_CYC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             policy_closed,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [ID_W-1:0]  req_id,
    output logic             cmd_valid,
    output logic [1:0]       cmd_kind,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             done_valid,
    output logic [ID_W-1:0]  done_id,
    output logic             busy,
    output logic             bank_open,
    output logic [ROW_W-1:0] bank_row
);
    bank_st_t         state, state_nx;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [ID_W-1:0]  id_q;
    logic             closed_q;
    logic             step_first, step_last;
    logic             accept;

    assign accept = req_valid && (state == ST_IDLE);

    bank_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state != ST_IDLE),
        .step_first (step_first),
        .step_last  (step_last)
    );

    bank_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_row   (cmd_row),
        .open_q    (bank_open),
        .row_q     (bank_row)
    );

    // State register and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            row_q    <= '0;
            col_q    <= '0;
            id_q     <= '0;
            closed_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                row_q    <= req_row;
                col_q    <= req_col;
                id_q     <= req_id;
                closed_q <= policy_closed;
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!bank_open)            state_nx = ST_ACT;
                    else if (req_row == bank_row) state_nx = ST_COL;
                    else                       state_nx = ST_PRE;
                end
            end
            ST_PRE:   if (step_last) state_nx = ST_ACT;
            ST_ACT:   if (step_last) state_nx = ST_COL;
            ST_COL:   if (step_last) state_nx = closed_q ? ST_CLOSE : ST_IDLE;
            ST_CLOSE: if (step_last) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_valid  = 1'b0;
        cmd_kind   = CMD_NOP;
        done_valid = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PRE, ST_CLOSE: begin
                cmd_valid = step_first;
                cmd_kind  = CMD_PRE;
            end
            ST_ACT: begin
                cmd_valid = step_first;
                cmd_kind  = CMD_ACT;
            end
            ST_COL: begin
                cmd_valid  = step_first;
                cmd_kind   = CMD_RD;
                done_valid = step_last;
            end
            default: ;
        endcase
    end

    assign cmd_row   = row_q;
    assign cmd_col   = col_q;
    assign done_id   = id_q;
    assign busy      = (state != ST_IDLE);
    assign req_ready = (state == ST_IDLE);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    a_r5_close_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && closed_q) |=> (cmd_valid && cmd_kind == CMD_PRE));
    a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && !done_valid));
    a_r7_policy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(closed_q));
endmodule

// File: tb/bank_rowbuf_ctrl_tb.sv
module bank_rowbuf_ctrl_tb;
    localparam int ROW_W = 8, COL_W = 6, ID_W = 4, STEP = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic policy_closed = 1'b0, req_valid = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [ID_W-1:0]  req_id = '0;
    logic req_ready, cmd_valid, done_valid, busy, bank_open;
    logic [1:0] cmd_kind;
    logic [ROW_W-1:0] cmd_row, bank_row;
    logic [COL_W-1:0] cmd_col;
    logic [ID_W-1:0]  done_id;

    int errors = 0, checks = 0;
    int n_pre = 0, n_act = 0, n_rd = 0;

    always #2 clk = ~clk;

    bank_rowbuf_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .ID_W(ID_W), .STEP_CYC(STEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .policy_closed(policy_closed),
        .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
        .req_col(req_col), .req_id(req_id), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .done_valid(done_valid), .done_id(done_id), .busy(busy),
        .bank_open(bank_open), .bank_row(bank_row)
    );

    always @(posedge clk) if (cmd_valid) begin
        if (cmd_kind == 2'd1) n_pre <= n_pre + 1;
        if (cmd_kind == 2'd2) n_act <= n_act + 1;
        if (cmd_kind == 2'd3) n_rd  <= n_rd + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one request and follow it to completion.
    task automatic run_req(input string req, input int row, input int id,
                           input int exp_cyc, input int e_pre, input int e_act, input int e_rd);
        int p0, a0, r0, n, ready_bad;
        @(negedge clk);
        req_valid = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(id); req_id = ID_W'(id);
        while (!req_ready) @(negedge clk);
        p0 = n_pre; a0 = n_act; r0 = n_rd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1; ready_bad = 0;
        while (!done_valid) begin
            if (req_ready) ready_bad++;
            @(negedge clk); n++;
        end
        check({req, " latency"}, n, exp_cyc);
        check({req, " done_id R8"}, int'(done_id), id);
        check({req, " PRE count"}, n_pre - p0, e_pre);
        check({req, " ACT count"}, n_act - a0, e_act);
        check({req, " RD count"}, n_rd - r0, e_rd);
        check("R6 ready low while busy", ready_bad, 0);
        @(negedge clk);
        check("R8 done one cycle", int'(done_valid), 0);
    endtask

    task automatic t_reset;
        check("R1 ready", int'(req_ready), 1);
        check("R1 busy", int'(busy), 0);
        check("R1 bank_open", int'(bank_open), 0);
        check("R1 no cmd/done", int'(cmd_valid | done_valid), 0);
    endtask

    task automatic t_open_cases;
        run_req("R2 empty", 3, 1, 2*STEP, 0, 1, 1);
        check("R2 row latched", int'(bank_open), 1);
        check("R2 latched row", int'(bank_row), 3);
        run_req("R3 hit", 3, 2, STEP, 0, 0, 1);
        run_req("R4 conflict", 7, 3, 3*STEP, 1, 1, 1);
        check("R4 new row", int'(bank_row), 7);
    endtask

    task automatic t_held;
        int m;
        @(negedge clk);
        req_valid = 1'b1; req_row = 8'd7; req_id = 4'd4;
        @(posedge clk);
        @(negedge clk);
        req_id = 4'd5; req_row = 8'd7;
        m = 1;
        while (!req_ready) begin @(negedge clk); m++; end
        check("R6 held request wait", m, STEP + 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done_valid) @(negedge clk);
        check("R8 order id", int'(done_id), 5);
    endtask

    task automatic t_policy;
        int p0;
        @(negedge clk);
        req_valid = 1'b1; req_row = 8'd7; req_id = 4'd6;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; policy_closed = 1'b1;
        while (!done_valid) @(negedge clk);
        repeat (STEP + 2) @(negedge clk);
        check("R7 policy change ignored, row kept", int'(bank_open), 1);
        // closed policy: row 7 still latched so this is a hit
        p0 = n_pre;
        run_req("R5 closed hit on kept row", 7, 7, STEP, 0, 0, 1);
        while (busy) @(negedge clk);
        check("R5 trailing PRE", n_pre - p0, 1);
        check("R5 bank empty", int'(bank_open), 0);
        run_req("R5 closed empty", 9, 8, 2*STEP, 0, 1, 1);
        while (busy) @(negedge clk);
        check("R5 bank empty after", int'(bank_open), 0);
        run_req("R5 closed other row", 11, 9, 2*STEP, 0, 1, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open_cases();
        t_held();
        t_policy();
        repeat (STEP * 2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule